// File: doc/BRIEF.md
# Mesh Router Port Fault Classifier

This block watches one mesh router and decides whether the faults it sees come from a single link or from the router itself. It keeps a packet count and a negative-acknowledge count for the router as a whole, and a second pair for each of the four directional ports. From each pair it forms an error ratio and compares it with a programmable threshold. No divider is used: the NACK count is scaled up by the threshold's fraction bits, and the threshold is multiplied by the packet count.

When the router-wide ratio is high, the block looks at which ports are high. If every port is high, it reports a router fault. If only some ports are high, it reports a link fault and returns a mask of those ports. Ports with too few packets are never flagged, so light traffic does not raise false alarms. A valid flag shows when the router-wide sample is large enough to trust. Downstream logic, such as rerouting or recovery, reads the verdict. This block only classifies.

Top module: `mesh_fault_classifier`

## Requirements
- R1: Ratio index 0 is the router-wide pair and indices 1 to 4 are north, south, west and east. Directional inputs and the fault_port mask use bit 0 = north, bit 1 = south, bit 2 = west and bit 3 = east.
- R2: Each strobe adds one to its own counter. Every counter saturates at 2^CW-1 and does not wrap.
- R3: A ratio is high exactly when its packet count is at least MIN_SAMPLES and nack_count * 2^TF >= threshold * packet_count.
- R4: When the router-wide ratio is high and all four port ratios are high, fault_type is 2'b10 (router) and fault_port is 4'b1111.
- R5: When the router-wide ratio is high and one to three port ratios are high, fault_type is 2'b01 (link) and fault_port marks exactly the high ports.
- R6: In every other case, fault_type is 2'b00 (none) and fault_port is zero. This covers a high router-wide ratio with no high port, and high ports with a low router-wide ratio. fault_type never takes the value 2'b11.
- R7: A port whose packet count is below MIN_SAMPLES is never flagged, whatever its NACK count.
- R8: The outputs are registered from the counters. A strobe sampled at one clock edge is visible on the outputs after the following edge.
- R9: class_valid rises one edge after the router-wide packet count reaches MIN_SAMPLES. It then stays high until reset. While it is low, fault_type is none.
- R10: An active-low asynchronous reset clears all counters and drives fault_type, fault_port and class_valid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_fwd | input | 1 | Packet forwarded by the router (router-wide count) |
| gen_nack | input | 1 | NACK logged for the router (router-wide count) |
| dir_fwd | input | 4 | Packet forwarded per port, bit order N,S,W,E |
| dir_nack | input | 4 | NACK logged per port, bit order N,S,W,E |
| threshold | input | TW | Ratio threshold, unsigned fraction with TF fraction bits |
| fault_type | output | 2 | 00 none, 01 link, 10 router |
| fault_port | output | 4 | Ports suspected faulty, bit order N,S,W,E |
| class_valid | output | 1 | Router-wide sample count reached MIN_SAMPLES |

## Verification
A counter that drops or repeats a strobe moves the ratio across the threshold one NACK too early or too late. This shows up two edges after the strobe as a wrong fault_type or mask bit, so the bench sweeps NACK counts across each threshold boundary. A judge stage that mixes up port indices shows the correct fault code with the wrong mask bit. A counter that wraps instead of saturating turns a low ratio into a high one, which shows on the outputs after the overflowing strobe. A valid flag that is late or early shows within one edge of the MIN_SAMPLES-th router-wide packet.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  localparam int NUM_DIRS   = 4;
  localparam int NUM_RATIOS = NUM_DIRS + 1;
  localparam int RIDX_GEN   = 0;

  typedef enum logic [1:0] {
    FT_NONE   = 2'b00,
    FT_LINK   = 2'b01,
    FT_ROUTER = 2'b10
  } fault_kind_e;

  typedef struct packed {
    fault_kind_e          kind;
    logic [NUM_DIRS-1:0]  mask;
  } verdict_t;

  // High when enough samples exist and nacks/pkts >= thr / 2^frac_bits
  function automatic logic ratio_exceeds(input logic [31:0] nacks,
                                         input logic [31:0] pkts,
                                         input logic [31:0] thr,
                                         input logic [31:0] min_samples,
                                         input int          frac_bits);
    logic [63:0] scaled_nacks;
    logic [63:0] scaled_thr;
    scaled_nacks = 64'(nacks) << frac_bits;
    scaled_thr   = 64'(thr) * 64'(pkts);
    return (pkts >= min_samples) && (scaled_nacks >= scaled_thr);
  endfunction

  // Router when all ports agree, link when only some do, none otherwise
  function automatic verdict_t classify(input logic gen_high,
                                        input logic [NUM_DIRS-1:0] port_high);
    verdict_t v;
    v.kind = FT_NONE;
    v.mask = '0;
    if (gen_high && (&port_high)) begin
      v.kind = FT_ROUTER;
      v.mask = '1;
    end else if (gen_high && (|port_high)) begin
      v.kind = FT_LINK;
      v.mask = port_high;
    end
    return v;
  endfunction

endpackage

// File: rtl/mfc_sat_counter.sv
module mfc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic at_max;
  assign at_max = (count == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (inc && !at_max)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/mfc_ratio_judge.sv
module mfc_ratio_judge
  import mfc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int TW          = 8,
  parameter int TF          = 6,
  parameter int MIN_SAMPLES = 8
) (
  input  logic [CW-1:0] pkt_cnt,
  input  logic [CW-1:0] nack_cnt,
  input  logic [TW-1:0] thr,
  output logic          high
);
  localparam logic [31:0] MIN_W = 32'(MIN_SAMPLES);

  always_comb
    high = ratio_exceeds(32'(nack_cnt), 32'(pkt_cnt), 32'(thr), MIN_W, TF);
endmodule

// File: rtl/mesh_fault_classifier.sv
module mesh_fault_classifier
  import mfc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int TW          = 8,
  parameter int TF          = 6,
  parameter int MIN_SAMPLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_fwd,
  input  logic          gen_nack,
  input  logic [3:0]    dir_fwd,
  input  logic [3:0]    dir_nack,
  input  logic [TW-1:0] threshold,
  output logic [1:0]    fault_type,
  output logic [3:0]    fault_port,
  output logic          class_valid
);
  localparam logic [CW-1:0] MIN_CNT = CW'(MIN_SAMPLES);

  logic [NUM_RATIOS-1:0] fwd_vec;
  logic [NUM_RATIOS-1:0] nack_vec;
  logic [NUM_RATIOS-1:0] high_vec;
  logic [CW-1:0]         pkt_cnt  [NUM_RATIOS];
  logic [CW-1:0]         nack_cnt [NUM_RATIOS];

  // Named internal events, brought out for the checker
  logic                  gen_high;
  logic [NUM_DIRS-1:0]   port_high;
  logic [CW-1:0]         gen_pkt_cnt;
  verdict_t              verdict_d;

  assign fwd_vec  = {dir_fwd,  gen_fwd};
  assign nack_vec = {dir_nack, gen_nack};

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
    mfc_sat_counter #(.W(CW)) u_pkt (
      .clk(clk), .rst_n(rst_n), .inc(fwd_vec[i]), .count(pkt_cnt[i])
    );
    mfc_sat_counter #(.W(CW)) u_nack (
      .clk(clk), .rst_n(rst_n), .inc(nack_vec[i]), .count(nack_cnt[i])
    );
    mfc_ratio_judge #(.CW(CW), .TW(TW), .TF(TF), .MIN_SAMPLES(MIN_SAMPLES)) u_judge (
      .pkt_cnt(pkt_cnt[i]), .nack_cnt(nack_cnt[i]), .thr(threshold), .high(high_vec[i])
    );
  end

  assign gen_high    = high_vec[RIDX_GEN];
  assign port_high   = high_vec[NUM_RATIOS-1:1];
  assign gen_pkt_cnt = pkt_cnt[RIDX_GEN];

  always_comb verdict_d = classify(gen_high, port_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_type  <= FT_NONE;
      fault_port  <= '0;
      class_valid <= 1'b0;
    end else begin
      fault_type  <= verdict_d.kind;
      fault_port  <= verdict_d.mask;
      class_valid <= (gen_pkt_cnt >= MIN_CNT);
    end
  end
endmodule

// File: rtl/mesh_fault_classifier_chk.sv
module mesh_fault_classifier_chk
  import mfc_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    fault_type,
  input logic [3:0]    fault_port,
  input logic          class_valid,
  input logic          gen_high,
  input logic [3:0]    port_high,
  input logic [CW-1:0] gen_pkt_cnt
);
  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    fault_type != 2'b11);

  a_r4_router_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fault_type == FT_ROUTER |-> fault_port == 4'hF);

  a_r5_link_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fault_type == FT_LINK |-> (fault_port != 4'h0 && fault_port != 4'hF));

  a_r6_none_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fault_type == FT_NONE |-> fault_port == 4'h0);

  a_r8_router_follows_judges: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault_type == FT_ROUTER) == ($past(gen_high) && ($past(port_high) == 4'hF)));

  a_r5_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault_port & ~$past(port_high)) == 4'h0);

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid |=> class_valid);

  a_r9_invalid_none: assert property (@(posedge clk) disable iff (!rst_n)
    !class_valid |-> fault_type == FT_NONE);

  a_r2_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gen_pkt_cnt >= $past(gen_pkt_cnt));
endmodule

bind mesh_fault_classifier mesh_fault_classifier_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_type(fault_type), .fault_port(fault_port),
  .class_valid(class_valid), .gen_high(gen_high), .port_high(port_high),
  .gen_pkt_cnt(gen_pkt_cnt)
);

// File: tb/mesh_fault_classifier_tb.sv
`timescale 1ns/1ps
module mesh_fault_classifier_tb;
  localparam int CW = 8, TW = 8, TF = 4, MINS = 4;
  localparam int SATV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_fwd = 1'b0, gen_nack = 1'b0;
  logic [3:0] dir_fwd = '0, dir_nack = '0;
  logic [TW-1:0] threshold = '0;
  logic [1:0] fault_type;
  logic [3:0] fault_port;
  logic class_valid;

  int vectors = 0;
  int errors  = 0;
  int pk [5];
  int nk [5];
  int thr_v;

  always #2 clk = ~clk;

  mesh_fault_classifier #(.CW(CW), .TW(TW), .TF(TF), .MIN_SAMPLES(MINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .gen_fwd(gen_fwd), .gen_nack(gen_nack),
    .dir_fwd(dir_fwd), .dir_nack(dir_nack), .threshold(threshold),
    .fault_type(fault_type), .fault_port(fault_port), .class_valid(class_valid)
  );

  function automatic int satc(input int x);
    return (x > SATV) ? SATV : x;
  endfunction

  function automatic bit is_high(input int p, input int n);
    int sp, sn;
    sp = satc(p);
    sn = satc(n);
    return (sp >= MINS) && (sn * (1 << TF) >= thr_v * sp);
  endfunction

  task automatic check(input string req, input logic [1:0] et,
                       input logic [3:0] em, input logic ev);
    vectors++;
    if (fault_type !== et || fault_port !== em || class_valid !== ev) begin
      errors++;
      $display("FAIL %s: type=%b/%b mask=%b/%b valid=%b/%b (actual/expected)",
               req, fault_type, et, fault_port, em, class_valid, ev);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    gen_fwd = 0; gen_nack = 0; dir_fwd = '0; dir_nack = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive the counts in pk/nk, then check against the arithmetic model
  task automatic run_case(input string req);
    int maxc;
    bit gh;
    logic [3:0] ph;
    logic [1:0] et;
    logic [3:0] em;
    do_reset();
    threshold = TW'(thr_v);
    maxc = 0;
    for (int i = 0; i < 5; i++) begin
      if (pk[i] > maxc) maxc = pk[i];
      if (nk[i] > maxc) maxc = nk[i];
    end
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      gen_fwd  = (c < pk[0]);
      gen_nack = (c < nk[0]);
      for (int i = 0; i < 4; i++) begin
        dir_fwd[i]  = (c < pk[i+1]);
        dir_nack[i] = (c < nk[i+1]);
      end
    end
    @(negedge clk);
    gen_fwd = 0; gen_nack = 0; dir_fwd = '0; dir_nack = '0;
    @(negedge clk);
    gh = is_high(pk[0], nk[0]);
    for (int i = 0; i < 4; i++) ph[i] = is_high(pk[i+1], nk[i+1]);
    if (gh && ph == 4'hF) begin et = 2'b10; em = 4'hF; end
    else if (gh && ph != 4'h0) begin et = 2'b01; em = ph; end
    else begin et = 2'b00; em = 4'h0; end
    check(req, et, em, satc(pk[0]) >= MINS);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    do_reset();
    @(negedge clk);
    check("R10 reset", 2'b00, 4'h0, 1'b0);

    // R1 R4 R5 R6: every port pattern, router-wide ratio high and low
    thr_v = 8;
    for (int g = 0; g < 2; g++) begin
      for (int pat = 0; pat < 16; pat++) begin
        for (int i = 0; i < 5; i++) pk[i] = 8;
        nk[0] = g ? 6 : 1;
        for (int i = 0; i < 4; i++) nk[i+1] = pat[i] ? 6 : 1;
        run_case("R1/R4/R5/R6 pattern sweep");
      end
    end

    // R3: ratio boundary, north NACKs against every threshold
    for (int n = 0; n <= 8; n++) begin
      for (int t = 0; t <= 16; t++) begin
        thr_v = t;
        for (int i = 0; i < 5; i++) begin pk[i] = 8; nk[i] = 0; end
        nk[0] = 8;
        nk[1] = n;
        run_case("R3 threshold boundary");
      end
    end

    // R7: sparse west port never flagged below MIN_SAMPLES
    thr_v = 8;
    for (int p = 0; p <= 6; p++) begin
      for (int i = 0; i < 5; i++) begin pk[i] = 8; nk[i] = 0; end
      nk[0] = 8;
      pk[3] = p;
      nk[3] = p;
      run_case("R7 sparse port");
    end

    // R9: valid threshold on router-wide count
    for (int p = 0; p <= 6; p++) begin
      for (int i = 0; i < 5; i++) begin pk[i] = 0; nk[i] = 0; end
      pk[0] = p;
      nk[0] = p;
      run_case("R9 valid count");
    end

    // R2: saturation, north 300 packets with 120 or 128 NACKs
    thr_v = 8;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 5; i++) begin pk[i] = 8; nk[i] = 0; end
      nk[0] = 8;
      pk[1] = 300;
      nk[1] = k ? 128 : 120;
      run_case("R2 saturation");
    end

    // R8 R9: exact latency of class_valid after the MIN_SAMPLES-th packet
    do_reset();
    threshold = 8'd8;
    for (int c = 0; c < MINS - 1; c++) begin
      @(negedge clk); gen_fwd = 1;
    end
    @(negedge clk); gen_fwd = 1;
    @(negedge clk); gen_fwd = 0;
    check("R8 one edge after count update", 2'b00, 4'h0, 1'b0);
    @(negedge clk);
    check("R8 R9 valid after second edge", 2'b00, 4'h0, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R9 valid stays high", 2'b00, 4'h0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule